// File: doc/BRIEF.md
# Flash Program/Erase Permission Unit

This block sits next to the command decoder of a serial flash device and decides whether a modifying command may run. For each Page Program, Sector Erase, Bulk Erase or status-write request that the decoder presents, the unit returns either a grant or a deny strobe one cycle later. A deny strobe carries a reason code. The unit also emits a strobe that tells the decoder to clear its write-enable latch.

The unit holds the protection part of the status byte: the block-protect level and the status-lock bit. It decides from that state, from the write-enable latch, from the external write-protect pin and from the array sector that the request address falls in. A granted status write loads new protection bits on the same edge that the grant appears. The full status byte is presented for read-out, with the write-enable and busy flags passed through from their inputs.

Top module: `wp_guard`

## Requirements
- R1: Each request (`req_valid_i` high) whose command is Page Program (code 1), Sector Erase (code 2), Bulk Erase (code 3) or Write Status (code 4) produces exactly one one-cycle pulse on `grant_o` or on `deny_o`, in the cycle after the edge that samples it. Code 0 and idle cycles produce neither pulse.
- R2: Any of the four commands presented with `wel_i` low is denied with reason 1. This check takes priority over every other check.
- R3: The protect level P = status bits 3:2 covers no sector when P=0, sector 3 when P=1, sectors 2 and 3 when P=2, and all four sectors when P=3. The sector is `req_addr_i[17:16]`, and address bits 23:18 are ignored. A Page Program or Sector Erase that falls in a covered sector is denied with reason 2. One that falls outside the covered sectors is granted.
- R4: Bulk Erase is granted only when P=0. With any other level it is denied with reason 2.
- R5: Write Status with `wel_i` high is denied with reason 3 when the lock bit (status bit 7) is 1 and `wp_n_i` is low. Otherwise it is granted.
- R6: A granted Write Status loads bit 7 and bits 3:2 of `wrsr_data_i` into the lock bit and the protect level, on the same edge as the grant. The other data bits are ignored. The stored bits change on no other event.
- R7: `status_o` is {lock, 3'b000, P, `wel_i`, `wip_i`}. After reset the stored bits equal parameter `SR_INIT` (default 0).
- R8: `wel_clr_o` pulses together with every grant and every deny, and at no other time. `deny_why_o` is 0 whenever `deny_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_cmd_i | input | 3 | Command code: 0 other, 1 page program, 2 sector erase, 3 bulk erase, 4 write status |
| req_addr_i | input | 24 | Byte address of the request |
| wrsr_data_i | input | 8 | Data byte for a status write |
| wel_i | input | 1 | Write-enable latch |
| wip_i | input | 1 | Busy flag, shown in status bit 0 |
| wp_n_i | input | 1 | External write-protect pin, active low |
| grant_o | output | 1 | One-cycle grant strobe |
| deny_o | output | 1 | One-cycle deny strobe |
| deny_why_o | output | 2 | Deny reason: 1 no write enable, 2 protected area, 3 status locked |
| wel_clr_o | output | 1 | One-cycle request to clear the write-enable latch |
| status_o | output | 8 | Status byte |

## Verification
The bench checks addresses on both sides of each protect-level boundary. A design that counted the covered sectors from the bottom of the array, or that was off by one sector, would grant a write into a covered sector or deny a write to an open one. It also sends addresses with high bits set, which catches a design that decodes the sector from the wrong address bits.

Bulk Erase is tried at a non-zero level and a locked status write is tried with the pin low. A locked write is also retried with the pin high, which catches a lock that ignores the pin. Status writes use data with every bit set, which exposes a mask that lets stray bits into the stored value. Requests sent without write enable are checked for the reason-1 priority. Every deny is checked for a write-enable clear strobe.

// File: rtl/wp_pkg.sv
// Package: shared command codes, deny reasons and status bit positions
// for the flash permission unit.
package wp_pkg;

    typedef enum logic [2:0] {
        CMD_OTHER = 3'd0,
        CMD_PP    = 3'd1,
        CMD_SE    = 3'd2,
        CMD_BE    = 3'd3,
        CMD_WRSR  = 3'd4
    } wp_cmd_e;

    typedef enum logic [1:0] {
        WHY_NONE   = 2'd0,
        WHY_NO_WEL = 2'd1,
        WHY_AREA   = 2'd2,
        WHY_LOCKED = 2'd3
    } wp_why_e;

    localparam int SR_LOCK_BIT = 7;
    localparam int SR_LVL_LSB  = 2;

endpackage

// File: rtl/wp_region_map.sv
// Module: wp_region_map
// Maps the protect level to the set of covered sectors and reports
// whether the request address lands in one of them.
// Assumes: level 0 covers nothing, the maximum level covers every sector,
// and level k in between covers the top 2**(k-1) sectors.
// Address bits above the array are ignored.
module wp_region_map #(
    parameter int ADDR_W    = 24,
    parameter int ARRAY_AW  = 18,
    parameter int SECTOR_AW = 16,
    parameter int LVL_W     = 2
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LVL_W-1:0]  level_i,
    output logic              hit_o
);
    localparam int IDX_W   = ARRAY_AW - SECTOR_AW;
    localparam int NSECT   = 1 << IDX_W;
    localparam int LVL_MAX = (1 << LVL_W) - 1;

    logic [IDX_W-1:0] sect_idx;
    logic [NSECT-1:0] sect_locked;
    int               cover_cnt;

    assign sect_idx = addr_i[ARRAY_AW-1:SECTOR_AW];

    logic unused_addr;
    assign unused_addr = ^{addr_i[ADDR_W-1:ARRAY_AW], addr_i[SECTOR_AW-1:0]};

    // Number of covered sectors for the current level.
    always_comb begin
        if (level_i == '0)
            cover_cnt = 0;
        else if (int'(level_i) == LVL_MAX)
            cover_cnt = NSECT;
        else if ((1 << (int'(level_i) - 1)) > NSECT)
            cover_cnt = NSECT;
        else
            cover_cnt = 1 << (int'(level_i) - 1);
    end

    // One lock flag per sector: the top cover_cnt sectors are covered.
    for (genvar s = 0; s < NSECT; s++) begin : g_sect
        assign sect_locked[s] = (cover_cnt + s) >= NSECT;
    end

    assign hit_o = sect_locked[sect_idx];

endmodule

// File: rtl/wp_decide.sv
// Module: wp_decide
// Combinational decision for one request. The checks are applied in
// priority order: write enable first, then the lock or area checks
// for the command.
// Assumes: the inputs are stable while req_i is high.
module wp_decide
    import wp_pkg::*;
#(
    parameter int LVL_W = 2
) (
    input  logic             req_i,
    input  logic [2:0]       cmd_i,
    input  logic             wel_i,
    input  logic             wp_n_i,
    input  logic             lock_i,
    input  logic [LVL_W-1:0] level_i,
    input  logic             area_hit_i,
    output logic             decide_o,
    output logic             accept_o,
    output logic [1:0]       why_o
);
    logic modifying;

    // A decision is owed only for the four modifying commands.
    always_comb begin
        case (cmd_i)
            CMD_PP, CMD_SE, CMD_BE, CMD_WRSR: modifying = 1'b1;
            default:                          modifying = 1'b0;
        endcase
    end

    assign decide_o = req_i && modifying;

    // Reason selection, in priority order.
    always_comb begin
        why_o = WHY_NONE;
        if (!wel_i) begin
            why_o = WHY_NO_WEL;
        end else begin
            case (cmd_i)
                CMD_PP, CMD_SE: if (area_hit_i)        why_o = WHY_AREA;
                CMD_BE:         if (level_i != '0)     why_o = WHY_AREA;
                CMD_WRSR:       if (lock_i && !wp_n_i) why_o = WHY_LOCKED;
                default:        why_o = WHY_NONE;
            endcase
        end
        if (!decide_o) why_o = WHY_NONE;
    end

    assign accept_o = decide_o && (why_o == WHY_NONE);

endmodule

// File: rtl/wp_status_reg.sv
// Module: wp_status_reg
// Holds the lock bit and the protect level. Loads them from the data
// byte on a granted status write only.
// Assumes: synchronous active-low reset to INIT.
module wp_status_reg
    import wp_pkg::*;
#(
    parameter int         LVL_W = 2,
    parameter logic [7:0] INIT  = 8'h00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [7:0]       data_i,
    output logic             lock_o,
    output logic [LVL_W-1:0] level_o
);
    logic unused_data;
    assign unused_data = ^{data_i[6:SR_LVL_LSB+LVL_W], data_i[SR_LVL_LSB-1:0]};

    // Stored protection bits: reset, or a load on a granted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_o  <= INIT[SR_LOCK_BIT];
            level_o <= INIT[SR_LVL_LSB +: LVL_W];
        end else if (load_i) begin
            lock_o  <= data_i[SR_LOCK_BIT];
            level_o <= data_i[SR_LVL_LSB +: LVL_W];
        end
    end

endmodule

// File: rtl/wp_guard.sv
// Module: wp_guard (top)
// Permission unit for the modifying commands of a serial flash. It
// registers a grant or deny strobe, with a reason code and a
// write-enable clear strobe, one cycle after each request. It also
// owns the protection bits of the status byte.
// Assumes: the decoder holds each request for one cycle.
module wp_guard
    import wp_pkg::*;
#(
    parameter int         ADDR_W    = 24,
    parameter int         ARRAY_AW  = 18,
    parameter int         SECTOR_AW = 16,
    parameter logic [7:0] SR_INIT   = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic [2:0]        req_cmd_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [7:0]        wrsr_data_i,
    input  logic              wel_i,
    input  logic              wip_i,
    input  logic              wp_n_i,
    output logic              grant_o,
    output logic              deny_o,
    output logic [1:0]        deny_why_o,
    output logic              wel_clr_o,
    output logic [7:0]        status_o
);
    localparam int LVL_W = 2;

    logic             lock_q;
    logic [LVL_W-1:0] level_q;
    logic             area_hit;
    logic             decide;
    logic             accept;
    logic [1:0]       why;

    wp_region_map #(
        .ADDR_W(ADDR_W), .ARRAY_AW(ARRAY_AW),
        .SECTOR_AW(SECTOR_AW), .LVL_W(LVL_W)
    ) u_map (
        .addr_i(req_addr_i), .level_i(level_q), .hit_o(area_hit)
    );

    wp_decide #(.LVL_W(LVL_W)) u_dec (
        .req_i(req_valid_i), .cmd_i(req_cmd_i), .wel_i(wel_i),
        .wp_n_i(wp_n_i), .lock_i(lock_q), .level_i(level_q),
        .area_hit_i(area_hit), .decide_o(decide), .accept_o(accept),
        .why_o(why)
    );

    wp_status_reg #(.LVL_W(LVL_W), .INIT(SR_INIT)) u_sr (
        .clk(clk), .rst_n(rst_n),
        .load_i(accept && (req_cmd_i == CMD_WRSR)),
        .data_i(wrsr_data_i), .lock_o(lock_q), .level_o(level_q)
    );

    // Output strobes: one cycle after the decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_o    <= 1'b0;
            deny_o     <= 1'b0;
            deny_why_o <= WHY_NONE;
            wel_clr_o  <= 1'b0;
        end else begin
            grant_o    <= accept;
            deny_o     <= decide && !accept;
            deny_why_o <= why;
            wel_clr_o  <= decide;
        end
    end

    // Status byte assembly.
    always_comb begin
        status_o                        = '0;
        status_o[SR_LOCK_BIT]           = lock_q;
        status_o[SR_LVL_LSB +: LVL_W]   = level_q;
        status_o[1]                     = wel_i;
        status_o[0]                     = wip_i;
    end

endmodule

// File: rtl/wp_guard_chk.sv
// Module: wp_guard_chk
// Property checker for wp_guard, attached through bind.
module wp_guard_chk
    import wp_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid_i,
    input logic [2:0]  req_cmd_i,
    input logic        wel_i,
    input logic        wp_n_i,
    input logic        grant_o,
    input logic        deny_o,
    input logic [1:0]  deny_why_o,
    input logic        wel_clr_o,
    input logic [7:0]  status_o
);
    logic mod_req;
    assign mod_req = req_valid_i && (req_cmd_i inside {CMD_PP, CMD_SE, CMD_BE, CMD_WRSR});

    a_r1_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_o && deny_o));
    a_r1_answer: assert property (@(posedge clk) disable iff (!rst_n)
        mod_req |=> (grant_o || deny_o));
    a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_req |=> !(grant_o || deny_o));
    a_r2_no_wel: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_req && !wel_i) |=> (deny_o && deny_why_o == WHY_NO_WEL));
    a_r4_bulk_level: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_cmd_i == CMD_BE && wel_i && status_o[3:2] != 2'b00)
        |=> (deny_o && deny_why_o == WHY_AREA));
    a_r5_hw_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_cmd_i == CMD_WRSR && wel_i && status_o[7] && !wp_n_i)
        |=> (deny_o && deny_why_o == WHY_LOCKED));
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid_i && req_cmd_i == CMD_WRSR) |=> $stable({status_o[7], status_o[3:2]}));
    a_r7_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[6:4] == 3'b000);
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        wel_clr_o == (grant_o || deny_o));
    a_r8_why_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !deny_o |-> deny_why_o == WHY_NONE);

endmodule

bind wp_guard wp_guard_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i),
    .req_cmd_i(req_cmd_i), .wel_i(wel_i), .wp_n_i(wp_n_i),
    .grant_o(grant_o), .deny_o(deny_o), .deny_why_o(deny_why_o),
    .wel_clr_o(wel_clr_o), .status_o(status_o)
);

// File: tb/sim_wp_guard.sv
// Scoreboard bench for wp_guard: the driver pushes expected results,
// and a monitor pops and compares them after each sampling edge.
module sim_wp_guard;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid_i = 1'b0;
    logic [2:0]  req_cmd_i = 3'd0;
    logic [23:0] req_addr_i = '0;
    logic [7:0]  wrsr_data_i = '0;
    logic        wel_i = 1'b0;
    logic        wip_i = 1'b0;
    logic        wp_n_i = 1'b1;
    logic        grant_o, deny_o, wel_clr_o;
    logic [1:0]  deny_why_o;
    logic [7:0]  status_o;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic       grant;
        logic       deny;
        logic [1:0] why;
        logic       clr;
        logic [7:0] status;
        string      tag;
    } exp_t;

    exp_t sb_q[$];

    // Bench model of the stored protection bits.
    logic       m_lock = 1'b0;
    logic [1:0] m_lvl  = 2'b00;

    always #(CLK_PERIOD/2) clk = ~clk;

    wp_guard u0 (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i),
        .req_cmd_i(req_cmd_i), .req_addr_i(req_addr_i),
        .wrsr_data_i(wrsr_data_i), .wel_i(wel_i), .wip_i(wip_i),
        .wp_n_i(wp_n_i), .grant_o(grant_o), .deny_o(deny_o),
        .deny_why_o(deny_why_o), .wel_clr_o(wel_clr_o), .status_o(status_o)
    );

    function automatic logic covered(input logic [1:0] lvl, input logic [23:0] a);
        case (lvl)
            2'd0: return 1'b0;
            2'd1: return a[17:16] == 2'd3;
            2'd2: return a[17];
            default: return 1'b1;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: presents one request and queues the result it should produce.
    task automatic send(input logic [2:0] cmd, input logic [23:0] a,
                        input logic [7:0] d, input logic wel, input logic wpn,
                        input string tag);
        exp_t e;
        logic mod;
        @(negedge clk);
        req_valid_i = 1'b1; req_cmd_i = cmd; req_addr_i = a;
        wrsr_data_i = d; wel_i = wel; wp_n_i = wpn;
        mod = cmd inside {3'd1, 3'd2, 3'd3, 3'd4};
        e.why = 2'd0;
        if (mod) begin
            if (!wel) e.why = 2'd1;
            else if ((cmd == 3'd1 || cmd == 3'd2) && covered(m_lvl, a)) e.why = 2'd2;
            else if (cmd == 3'd3 && m_lvl != 2'd0) e.why = 2'd2;
            else if (cmd == 3'd4 && m_lock && !wpn) e.why = 2'd3;
        end
        e.grant = mod && e.why == 2'd0;
        e.deny  = mod && e.why != 2'd0;
        e.clr   = mod;
        if (e.grant && cmd == 3'd4) begin
            m_lock = d[7];
            m_lvl  = d[3:2];
        end
        e.status = {m_lock, 3'b000, m_lvl, wel, 1'b0};
        e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
        req_valid_i = 1'b0; req_cmd_i = 3'd0; wel_i = 1'b0; wp_n_i = 1'b1;
    endtask

    // Monitor: after each edge that sampled a request, compare with the queue.
    always @(posedge clk) begin
        #1;
        if (rst_n && req_valid_i) begin
            if (sb_q.size() == 0) begin
                errors++;
                $display("FAIL R1 result with empty scoreboard actual=1 expected=0");
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check({e.tag, " grant"}, 32'(grant_o), 32'(e.grant));
                check({e.tag, " deny"}, 32'(deny_o), 32'(e.deny));
                check({e.tag, " why"}, 32'(deny_why_o), 32'(e.why));
                check({"R8 ", e.tag, " wel_clr"}, 32'(wel_clr_o), 32'(e.clr));
                check({"R6 R7 ", e.tag, " status"}, 32'(status_o), 32'(e.status));
            end
        end else if (rst_n && (grant_o || deny_o || wel_clr_o)) begin
            errors++;
            $display("FAIL R1 strobe without request actual=%b%b%b expected=000",
                     grant_o, deny_o, wel_clr_o);
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 reset status", 32'(status_o), 32'h00);
        check("R1 reset strobes", 32'({grant_o, deny_o, wel_clr_o}), 32'd0);
        wip_i = 1'b1;
        #1 check("R7 busy passthrough", 32'(status_o), 32'h01);
        wip_i = 1'b0;

        send(3'd1, 24'h000100, 8'h00, 1'b0, 1'b1, "R2 pp no wel");
        send(3'd4, 24'h0, 8'h8C, 1'b0, 1'b1, "R2 wrsr no wel");
        send(3'd0, 24'h0, 8'h00, 1'b1, 1'b1, "R1 other cmd");
        send(3'd1, 24'h03FFFF, 8'h00, 1'b1, 1'b1, "R3 level0 top");
        send(3'd3, 24'h0, 8'h00, 1'b1, 1'b1, "R4 bulk level0");
        send(3'd4, 24'h0, 8'h73, 1'b1, 1'b1, "R6 masked bits");
        send(3'd4, 24'h0, 8'h04, 1'b1, 1'b1, "R6 level1");
        send(3'd1, 24'h030000, 8'h00, 1'b1, 1'b1, "R3 level1 inside");
        send(3'd2, 24'h02FFFF, 8'h00, 1'b1, 1'b1, "R3 level1 below");
        send(3'd3, 24'h0, 8'h00, 1'b1, 1'b1, "R4 bulk level1");
        send(3'd1, 24'h030000, 8'h00, 1'b0, 1'b1, "R2 priority over area");
        send(3'd4, 24'h0, 8'h08, 1'b1, 1'b1, "R6 level2");
        send(3'd2, 24'h020000, 8'h00, 1'b1, 1'b1, "R3 level2 edge");
        send(3'd1, 24'h01FFFF, 8'h00, 1'b1, 1'b1, "R3 level2 below");
        send(3'd1, 24'hFD0000, 8'h00, 1'b1, 1'b1, "R3 high bits sector1");
        send(3'd1, 24'h420000, 8'h00, 1'b1, 1'b1, "R3 high bits sector2");
        send(3'd4, 24'h0, 8'hFF, 1'b1, 1'b1, "R6 level3 lock");
        send(3'd2, 24'h000000, 8'h00, 1'b1, 1'b1, "R3 level3 bottom");
        send(3'd4, 24'h0, 8'h00, 1'b1, 1'b0, "R5 locked pin low");
        send(3'd3, 24'h0, 8'h00, 1'b1, 1'b0, "R4 bulk level3");
        send(3'd4, 24'h0, 8'h00, 1'b1, 1'b1, "R5 locked pin high");
        send(3'd4, 24'h0, 8'h00, 1'b1, 1'b0, "R5 unlocked pin low");
        send(3'd1, 24'h03FFFF, 8'h00, 1'b1, 1'b1, "R3 level0 again");

        repeat (3) @(negedge clk);
        check("R1 scoreboard drained", 32'(sb_q.size()), 32'd0);
        check("R1 idle strobes", 32'({grant_o, deny_o, wel_clr_o}), 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule